// File: doc/BRIEF.md
# ECC Fault Response Unit

This unit sits next to the buffer-configuration RAM and the protocol-engine program RAM of a time-triggered bus controller. Each cycle it may receive one ECC check result. The result describes:
- which memory was read;
- whether the controller itself or the application started the read;
- the buffer index or address, and for buffer reads whether the buffer transmits or receives;
- a corrected-error flag;
- a 5-bit syndrome code.

Only uncorrectable results get a response, and only while the global ECC enable is set. What happens depends on the source of the read:
- A controller read of a buffer entry that fails takes that buffer out of the current slot's search. The unit keeps separate transmit and receive skip masks for this.
- An application read of a buffer entry that fails is only reported.
- A controller read of program memory that fails is fatal. So is an application read of program memory while the protocol sits in its default-configuration state. A fatal error raises a freeze request in the same cycle.

Every uncorrectable error is a candidate for the report register. The register latches the first error that has not yet been reported. It then holds the error flag until the application writes one to clear it.

There are two state machines:
- Report machine:
  - `RPT_EMPTY --capture--> RPT_HELD` on an uncorrectable error.
  - `RPT_HELD --release--> RPT_EMPTY` on a clear with no new error in the same cycle.
  - `RPT_HELD --recapture--> RPT_HELD` on a clear that coincides with a new error.
- Freeze machine:
  - `FRZ_RUN --halt--> FRZ_HALTED` on a fatal error.
  - `FRZ_HALTED` is left only by reset.

Top module: `ecc_fault_responder`

## Requirements
- R1: While `ecc_en` is low, check results change no skip bit, no report field, the flag or the freeze request.
- R2: A result with `chk_corr` high, or with `chk_code` equal to 0, causes no response at all.
- R3: An uncorrectable result with `chk_region`=0 (buffer configuration) and `chk_app`=0 sets bit `chk_idx` of `skip_tx` (when `chk_tx`=1) or of `skip_rx` (when `chk_tx`=0) one cycle later. Other bits are unchanged. An index at or above NUM_BUF sets no bit.
- R4: `slot_start` clears both skip masks one cycle later. A buffer error in the same cycle is applied after the clear.
- R5: An uncorrectable result with `chk_region`=0 and `chk_app`=1 sets no skip bit and no freeze. It is only reported.
- R6: An uncorrectable result with `chk_region`=1 (program memory) and `chk_app`=0 drives `freeze_req` high in the same cycle.
- R7: An uncorrectable result with `chk_region`=1 and `chk_app`=1 raises `freeze_req` only when `poc_default_cfg` is high.
- R8: Once `freeze_req` has been latched high, it stays high until reset, whatever further errors arrive.
- R9: Out of reset, `err_flag` is low. When the flag is low, an uncorrectable result latches its region, read source, index/address and code into the `rpt_*` outputs and raises `err_flag` one cycle later. While the flag is high, further errors leave the report unchanged.
- R10: `err_clr` high lowers `err_flag` one cycle later. If a new uncorrectable result arrives in that same cycle, it is captured and the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Global ECC response enable |
| poc_default_cfg | input | 1 | Protocol is in default-configuration state |
| slot_start | input | 1 | Start of a new slot search |
| chk_valid | input | 1 | A check result is present |
| chk_region | input | 1 | 0 = buffer configuration RAM, 1 = program RAM |
| chk_app | input | 1 | 1 = application read, 0 = controller read |
| chk_tx | input | 1 | Buffer is a transmit buffer |
| chk_corr | input | 1 | Error was corrected |
| chk_idx | input | ADDR_W | Buffer index or program address |
| chk_code | input | CODE_W | Syndrome code, nonzero = uncorrectable |
| err_clr | input | 1 | Write-one-to-clear of the error flag |
| skip_tx | output | NUM_BUF | Transmit buffers excluded this slot |
| skip_rx | output | NUM_BUF | Receive buffers excluded this slot |
| freeze_req | output | 1 | Protocol freeze request |
| err_flag | output | 1 | Unreported error pending |
| rpt_region | output | 1 | Captured region |
| rpt_app | output | 1 | Captured read source |
| rpt_addr | output | ADDR_W | Captured index or address |
| rpt_code | output | CODE_W | Captured syndrome code |

## Verification
A skip bit that is wrongly set or left standing shows up on `skip_tx`/`skip_rx` one cycle after the error or the slot start. A wrongly decoded source shows up as a missing or spurious `freeze_req` in the same cycle as the error. A report machine stuck in the wrong state shows up as a flag that fails to rise or fall one cycle after capture or clear, or as report fields overwritten by a later error. Because the reference model is compared on every cycle, each of these is seen within one or two cycles of the stimulus that exposes it.

// File: rtl/ecc_resp_pkg.sv
package ecc_resp_pkg;

    typedef enum logic {
        RPT_EMPTY = 1'b0,
        RPT_HELD  = 1'b1
    } rpt_state_t;

    typedef enum logic {
        FRZ_RUN    = 1'b0,
        FRZ_HALTED = 1'b1
    } frz_state_t;

    localparam logic RGN_BUFCFG = 1'b0;
    localparam logic RGN_PROG   = 1'b1;

endpackage

// File: rtl/ecc_skip_mask.sv
module ecc_skip_mask #(
    parameter int NUM_BUF = 16,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               set_en,
    input  logic               set_tx,
    input  logic [ADDR_W-1:0]  set_idx,
    output logic [NUM_BUF-1:0] skip_tx,
    output logic [NUM_BUF-1:0] skip_rx
);
    logic [NUM_BUF-1:0] tx_q;
    logic [NUM_BUF-1:0] rx_q;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_bit
        logic hit;
        assign hit = set_en && (set_idx == ADDR_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_q[g] <= 1'b0;
                rx_q[g] <= 1'b0;
            end else begin
                tx_q[g] <= (tx_q[g] && !clr) || (hit && set_tx);
                rx_q[g] <= (rx_q[g] && !clr) || (hit && !set_tx);
            end
        end
    end

    assign skip_tx = tx_q;
    assign skip_rx = rx_q;

    // R4: a slot start with no new error leaves both masks empty
    a_r4_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_en) |=> (skip_tx == '0 && skip_rx == '0));

    // R3: without a clear, bits already set stay set
    a_r3_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (((skip_tx & $past(skip_tx)) == $past(skip_tx)) &&
                  ((skip_rx & $past(skip_rx)) == $past(skip_rx))));
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
    import ecc_resp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_ev,
    input  logic              clr,
    input  logic              in_region,
    input  logic              in_app,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CODE_W-1:0] in_code,
    output logic              flag,
    output logic              rpt_region,
    output logic              rpt_app,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [CODE_W-1:0] rpt_code
);
    rpt_state_t st_q, st_d;
    logic       cap;

    always_comb begin
        st_d = st_q;
        cap  = 1'b0;
        unique case (st_q)
            RPT_EMPTY: begin
                if (err_ev) begin
                    cap  = 1'b1;
                    st_d = RPT_HELD;
                end
            end
            RPT_HELD: begin
                if (clr) begin
                    if (err_ev) cap = 1'b1;
                    else        st_d = RPT_EMPTY;
                end
            end
            default: st_d = RPT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RPT_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_region <= 1'b0;
            rpt_app    <= 1'b0;
            rpt_addr   <= '0;
            rpt_code   <= '0;
        end else if (cap) begin
            rpt_region <= in_region;
            rpt_app    <= in_app;
            rpt_addr   <= in_addr;
            rpt_code   <= in_code;
        end
    end

    assign flag = (st_q == RPT_HELD);

    // R9: a held report is never overwritten while uncleared
    a_r9_report_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(rpt_code) && $stable(rpt_addr) && $stable(rpt_region)));

    // R9: a raised flag always carries a nonzero code
    a_r9_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (rpt_code != '0));

    // R10: a clear without a coincident error drops the flag
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !err_ev) |=> !flag);
endmodule

// File: rtl/ecc_freeze_ctl.sv
module ecc_freeze_ctl
    import ecc_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fatal,
    output logic freeze_req
);
    frz_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FRZ_RUN:    if (fatal) st_d = FRZ_HALTED;
            FRZ_HALTED: st_d = FRZ_HALTED;
            default:    st_d = FRZ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRZ_RUN;
        else        st_q <= st_d;
    end

    assign freeze_req = (st_q == FRZ_HALTED) || fatal;

    // R8: the request never falls once raised
    a_r8_freeze_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_req |=> freeze_req);
endmodule

// File: rtl/ecc_fault_responder.sv
module ecc_fault_responder
    import ecc_resp_pkg::*;
#(
    parameter int NUM_BUF = 16,
    parameter int ADDR_W  = 10,
    parameter int CODE_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ecc_en,
    input  logic               poc_default_cfg,
    input  logic               slot_start,
    input  logic               chk_valid,
    input  logic               chk_region,
    input  logic               chk_app,
    input  logic               chk_tx,
    input  logic               chk_corr,
    input  logic [ADDR_W-1:0]  chk_idx,
    input  logic [CODE_W-1:0]  chk_code,
    input  logic               err_clr,
    output logic [NUM_BUF-1:0] skip_tx,
    output logic [NUM_BUF-1:0] skip_rx,
    output logic               freeze_req,
    output logic               err_flag,
    output logic               rpt_region,
    output logic               rpt_app,
    output logic [ADDR_W-1:0]  rpt_addr,
    output logic [CODE_W-1:0]  rpt_code
);
    localparam int IDX_SPAN = 1 << ADDR_W;

    logic uncorr;
    logic buf_ctl_err;
    logic fatal_now;

    assign uncorr      = chk_valid && ecc_en && !chk_corr && (chk_code != '0);
    assign buf_ctl_err = uncorr && (chk_region == RGN_BUFCFG) && !chk_app;
    assign fatal_now   = uncorr && (chk_region == RGN_PROG) && (!chk_app || poc_default_cfg);

    ecc_skip_mask #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (slot_start),
        .set_en  (buf_ctl_err),
        .set_tx  (chk_tx),
        .set_idx (chk_idx),
        .skip_tx (skip_tx),
        .skip_rx (skip_rx)
    );

    ecc_err_report #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_ev     (uncorr),
        .clr        (err_clr),
        .in_region  (chk_region),
        .in_app     (chk_app),
        .in_addr    (chk_idx),
        .in_code    (chk_code),
        .flag       (err_flag),
        .rpt_region (rpt_region),
        .rpt_app    (rpt_app),
        .rpt_addr   (rpt_addr),
        .rpt_code   (rpt_code)
    );

    ecc_freeze_ctl u_frz (
        .clk        (clk),
        .rst_n      (rst_n),
        .fatal      (fatal_now),
        .freeze_req (freeze_req)
    );

    initial begin
        if (NUM_BUF > IDX_SPAN) $error("NUM_BUF exceeds index range");
    end

    // R6: controller read of program memory freezes in the same cycle
    a_r6_freeze_now: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && ecc_en && !chk_corr && chk_code != '0 &&
         chk_region && !chk_app) |-> freeze_req);

    // R1: disabled responses leave the masks untouched
    a_r1_masks_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && !slot_start) |=> ($stable(skip_tx) && $stable(skip_rx)));

    // R1: disabled responses never raise the flag
    a_r1_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && !err_flag) |=> !err_flag);

    // R5: application read of a buffer entry never sets a skip bit
    a_r5_app_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_region && chk_app && !slot_start) |=>
        ($stable(skip_tx) && $stable(skip_rx)));
endmodule

// File: tb/sim_ecc_fault_responder.sv
`timescale 1ns/1ps
module sim_ecc_fault_responder;
    localparam int NB = 16;
    localparam int AW = 10;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ecc_en = 1'b0, poc_default_cfg = 1'b0, slot_start = 1'b0;
    logic chk_valid = 1'b0, chk_region = 1'b0, chk_app = 1'b0, chk_tx = 1'b0, chk_corr = 1'b0;
    logic [AW-1:0] chk_idx = '0;
    logic [CW-1:0] chk_code = '0;
    logic err_clr = 1'b0;
    logic [NB-1:0] skip_tx, skip_rx;
    logic freeze_req, err_flag, rpt_region, rpt_app;
    logic [AW-1:0] rpt_addr;
    logic [CW-1:0] rpt_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    ecc_fault_responder #(.NUM_BUF(NB), .ADDR_W(AW), .CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .poc_default_cfg(poc_default_cfg),
        .slot_start(slot_start), .chk_valid(chk_valid), .chk_region(chk_region),
        .chk_app(chk_app), .chk_tx(chk_tx), .chk_corr(chk_corr), .chk_idx(chk_idx),
        .chk_code(chk_code), .err_clr(err_clr), .skip_tx(skip_tx), .skip_rx(skip_rx),
        .freeze_req(freeze_req), .err_flag(err_flag), .rpt_region(rpt_region),
        .rpt_app(rpt_app), .rpt_addr(rpt_addr), .rpt_code(rpt_code)
    );

    // behavioural reference model
    bit m_tx[NB];
    bit m_rx[NB];
    bit m_frz, m_flag, m_rgn, m_app;
    int m_addr, m_code;

    function automatic bit is_uncorr();
        return chk_valid && ecc_en && !chk_corr && (chk_code != 0);
    endfunction

    function automatic bit is_fatal();
        if (!is_uncorr() || chk_region != 1'b1) return 0;
        if (!chk_app) return 1;
        return poc_default_cfg;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_tx[i]) begin m_tx[i] = 0; m_rx[i] = 0; end
            m_frz = 0; m_flag = 0; m_rgn = 0; m_app = 0; m_addr = 0; m_code = 0;
        end else begin
            if (slot_start) foreach (m_tx[i]) begin m_tx[i] = 0; m_rx[i] = 0; end
            if (is_uncorr() && chk_region == 1'b0 && !chk_app && int'(chk_idx) < NB) begin
                if (chk_tx) m_tx[int'(chk_idx)] = 1;
                else        m_rx[int'(chk_idx)] = 1;
            end
            if (is_fatal()) m_frz = 1;
            if (m_flag && err_clr) m_flag = 0;
            if (!m_flag && is_uncorr()) begin
                m_flag = 1; m_rgn = chk_region; m_app = chk_app;
                m_addr = int'(chk_idx); m_code = int'(chk_code);
            end
        end
    end

    task automatic check(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        longint etx = 0, erx = 0;
        for (int i = 0; i < NB; i++) begin
            if (m_tx[i]) etx = etx | (longint'(1) << i);
            if (m_rx[i]) erx = erx | (longint'(1) << i);
        end
        check("skip_tx", longint'(skip_tx), etx);
        check("skip_rx", longint'(skip_rx), erx);
        check("freeze_req", longint'(freeze_req), longint'(m_frz || is_fatal()));
        check("err_flag", longint'(err_flag), longint'(m_flag));
        check("rpt_region", longint'(rpt_region), longint'(m_rgn));
        check("rpt_app", longint'(rpt_app), longint'(m_app));
        check("rpt_addr", longint'(rpt_addr), longint'(m_addr));
        check("rpt_code", longint'(rpt_code), longint'(m_code));
    endtask

    // one cycle: compare at the falling edge, then apply the next inputs
    task automatic cyc(bit v, bit rgn, bit app, bit tx, bit corr, int idx, int code, bit slot, bit clr);
        @(negedge clk);
        if (rst_n) compare_all();
        chk_valid = v; chk_region = rgn; chk_app = app; chk_tx = tx; chk_corr = corr;
        chk_idx = AW'(idx); chk_code = CW'(code); slot_start = slot; err_clr = clr;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle(2);
        @(negedge clk);
        rst_n = 1;
        idle(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-reqs actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cur_req = "R9";
        do_reset();
        idle(2);

        cur_req = "R1";
        ecc_en = 0;
        cyc(1, 0, 0, 1, 0, 3, 5, 0, 0);
        cyc(1, 1, 0, 0, 0, 40, 7, 0, 0);
        idle(2);
        check("R1 flag stays low", longint'(err_flag), 0);

        cur_req = "R2";
        ecc_en = 1;
        cyc(1, 0, 0, 1, 1, 3, 5, 0, 0);
        cyc(1, 1, 0, 0, 0, 40, 0, 0, 0);
        cyc(1, 1, 0, 0, 1, 41, 9, 0, 0);
        idle(2);
        check("R2 no freeze", longint'(freeze_req), 0);

        cur_req = "R3";
        cyc(1, 0, 0, 1, 0, 2, 3, 0, 0);
        cyc(1, 0, 0, 0, 0, 15, 4, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 6, 0, 0);
        cyc(1, 0, 0, 1, 0, 16, 6, 0, 0);
        cyc(1, 0, 0, 0, 0, 7, 31, 0, 0);
        idle(2);

        cur_req = "R4";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle(1);
        check("R4 masks empty", longint'(skip_tx | skip_rx), 0);
        cyc(1, 0, 0, 1, 0, 9, 2, 0, 0);
        cyc(1, 0, 0, 0, 0, 4, 2, 1, 0);
        idle(2);

        cur_req = "R10";
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle(1);
        check("R10 flag cleared", longint'(err_flag), 0);

        cur_req = "R5";
        cyc(1, 0, 1, 1, 0, 5, 17, 0, 0);
        idle(2);
        check("R5 report only", longint'(rpt_code), 17);

        cur_req = "R9";
        cyc(1, 0, 0, 0, 0, 6, 12, 0, 0);
        idle(1);
        check("R9 first error kept", longint'(rpt_addr), 5);

        cur_req = "R10";
        cyc(1, 1, 1, 0, 0, 300, 21, 0, 1);
        idle(2);
        check("R10 recapture", longint'(rpt_code), 21);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);

        cur_req = "R7";
        poc_default_cfg = 0;
        cyc(1, 1, 1, 0, 0, 512, 8, 0, 0);
        idle(2);
        check("R7 no freeze outside cfg", longint'(freeze_req), 0);

        cur_req = "R6";
        cyc(1, 1, 0, 0, 0, 700, 30, 0, 0);
        idle(1);

        cur_req = "R8";
        ecc_en = 0;
        idle(3);
        check("R8 still frozen", longint'(freeze_req), 1);
        ecc_en = 1;
        cyc(1, 1, 0, 0, 1, 1, 1, 0, 1);
        idle(3);

        cur_req = "R7";
        do_reset();
        check("R7 reset clears freeze", longint'(freeze_req), 0);
        poc_default_cfg = 1;
        cyc(1, 1, 1, 0, 0, 123, 19, 0, 0);
        idle(2);
        check("R7 freeze in cfg state", longint'(freeze_req), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule